// File: doc/BRIEF.md
# Wake-up frame pattern filter

This block watches the byte stream of received Ethernet frames and raises a wake-up event when one of four programmable pattern filters recognises a frame. Each filter picks a window of up to 31 frame bytes. The window starts at a per-filter start position, and a mask chooses which bytes inside it count. A CRC-16 is folded over only the chosen bytes. When the frame ends, a filter hits if it is enabled, its start position is legal, every chosen byte has arrived, and its CRC equals the value the host programmed. The frame must also carry a passing indication from the external address filter.

The host loads the filters through a single data port using a fixed cycle of eight writes. A pointer reset strobe restarts that cycle. A control port sets the detection enable, picks which notification outputs follow the status bit, and clears the status bit. While detection is active, the normal receive path is told to stop forwarding frames. Detection is also forced on whenever the low-power state input is high.

Top module: `wkf_pattern_filter`

## Requirements
- R1: Configuration words land in this fixed order: mask of filter 0, 1, 2, 3, then the command word, then the start-position word, then CRC word A, then CRC word B. A mask word uses bits [30:0]. In the command word, bit 8*i enables filter i. In the start-position word, byte i (bits [8*i+7:8*i]) is the start of filter i. CRC word A carries filter 0 in [15:0] and filter 1 in [31:16]. CRC word B does the same for filters 2 and 3. `cfg_rst_i` returns the pointer to the first slot and drops any write in the same cycle. A write after the eighth goes back to the first slot.
- R2: Frame byte 0 is the first byte with `byte_vld_i` after a `sof_i` strobe. When mask bit j of filter i is set, frame byte (start + j) goes into that filter's CRC. All other bytes leave that CRC unchanged.
- R3: The CRC-16 starts each frame at 0xFFFF and uses the reflected polynomial 0xA001 (x^16+x^15+x^2+1), with each byte taken LSB first. The nine bytes "123456789" give 0x4B37.
- R4: A filter whose start position is 12 or less never hits.
- R5: `wake_rcvd_o` is set at the `eof_i` cycle only when `addr_pass_i` is high in that cycle and at least one enabled filter hits. Any of the four filters is enough.
- R6: A filter whose mask is all zero never hits. A filter also does not hit if the frame ends before the byte at its highest set mask bit.
- R7: Detection is active when the enable bit (`ctl_wdata_i[0]`) is held set, or when `pwr_d1_i` is high. When it is not active, no frame sets the status.
- R8: `rx_fwd_o` is low exactly while detection is active, and high otherwise.
- R9: `wake_rcvd_o` stays set until a control write with bit 3 set clears it. If a new detection arrives in the same cycle as the clear, the detection wins.
- R10: `irq_o` follows the status bit when control bit 1 is set. `pme_o` follows the status bit when control bit 2 is set. Each control write replaces bits 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_rst_i | input | 1 | Returns the configuration write pointer to slot 0 |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 4 | Control bits: [0] enable, [1] irq select, [2] pme select, [3] clear status |
| pwr_d1_i | input | 1 | Low-power state; forces detection on |
| sof_i | input | 1 | Start-of-frame strobe, in the cycle before byte 0 |
| byte_vld_i | input | 1 | Frame byte valid |
| byte_i | input | 8 | Frame byte |
| eof_i | input | 1 | End-of-frame strobe, after the last byte |
| addr_pass_i | input | 1 | Address filter verdict, valid with eof_i |
| wake_rcvd_o | output | 1 | Sticky wake-up frame status |
| irq_o | output | 1 | Interrupt notification |
| pme_o | output | 1 | Power-management event notification |
| rx_fwd_o | output | 1 | Normal receive forwarding allowed |

## Verification
The bench builds the block with its default parameters: four filters, a 31-byte mask and an 11-bit position counter. With these values a start position anywhere up to 50 and frames up to 100 bytes are exercised, so the whole mask window, cut-off frames and the smallest legal start position are all reached. Directed frames check the standard CRC check value, the write-pointer wrap and the power-state override. Random configurations are then compared against a reference CRC and hit model written in the bench.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int NUM_FILT = 4;
  localparam int MASK_W   = 31;
  localparam int OFF_W    = 8;
  localparam int CRC_W    = 16;
  localparam int DW       = 32;
  localparam int POS_W    = 11;
  localparam int MIN_OFF  = 13;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'hA001;
  localparam logic [CRC_W-1:0] CRC_INIT     = 16'hFFFF;

  typedef struct packed {
    logic              en;
    logic [OFF_W-1:0]  off;
    logic [MASK_W-1:0] mask;
    logic [CRC_W-1:0]  crc;
  } filt_cfg_t;

  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REV;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/wkf_cfg_regs.sv
module wkf_cfg_regs
  import wkf_pkg::*;
#(
  parameter int N_FILT = NUM_FILT,
  parameter int W_DATA = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rst_i,
  input  logic              cfg_wr_i,
  input  logic [W_DATA-1:0] cfg_wdata_i,
  output filt_cfg_t         cfg_o [N_FILT]
);
  localparam int CMD_IDX = N_FILT;
  localparam int OFF_IDX = N_FILT + 1;
  localparam int CRC_IDX = N_FILT + 2;
  localparam int NUM_WR  = N_FILT + 2 + N_FILT / 2;
  localparam int PTR_W   = $clog2(NUM_WR);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WR - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [W_DATA-1:0] words_q [NUM_WR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int k = 0; k < NUM_WR; k++) words_q[k] <= '0;
    end else if (cfg_rst_i) begin
      ptr_q <= '0;
    end else if (cfg_wr_i) begin
      words_q[ptr_q] <= cfg_wdata_i;
      ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_FILT; i++) begin : g_dec
    assign cfg_o[i].mask = words_q[i][MASK_W-1:0];
    assign cfg_o[i].en   = words_q[CMD_IDX][8*i];
    assign cfg_o[i].off  = words_q[OFF_IDX][8*i +: OFF_W];
    assign cfg_o[i].crc  = words_q[CRC_IDX + i/2][CRC_W*(i%2) +: CRC_W];
  end

  assert_ptr_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !cfg_rst_i && ptr_q == LAST |=> ptr_q == '0);
  assert_ptr_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_i |=> ptr_q == '0);
endmodule

// File: rtl/wkf_filter_lane.sv
module wkf_filter_lane
  import wkf_pkg::*;
#(
  parameter int W_POS   = POS_W,
  parameter int W_MASK  = MASK_W,
  parameter int OFF_MIN = MIN_OFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  filt_cfg_t        cfg_i,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [W_POS-1:0] pos_i,
  output logic             hit_o
);
  localparam int IDX_W = $clog2(W_MASK);

  logic [W_POS-1:0] off_ext, diff;
  logic [IDX_W-1:0] idx, hi_idx;
  logic             in_win, sel, last;
  logic [CRC_W-1:0] crc_q;
  logic             seen_q;

  assign off_ext = W_POS'(cfg_i.off);
  assign diff    = pos_i - off_ext;
  assign in_win  = (pos_i >= off_ext) && (diff < W_POS'(W_MASK));
  assign idx     = diff[IDX_W-1:0];
  assign sel     = byte_vld_i && in_win && cfg_i.mask[idx];
  assign last    = sel && (idx == hi_idx);

  always_comb begin
    hi_idx = '0;
    for (int k = 0; k < W_MASK; k++)
      if (cfg_i.mask[k]) hi_idx = IDX_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= CRC_INIT;
      seen_q <= 1'b0;
    end else if (sof_i) begin
      crc_q  <= CRC_INIT;
      seen_q <= 1'b0;
    end else if (sel) begin
      crc_q <= crc16_byte(crc_q, byte_i);
      if (last) seen_q <= 1'b1;
    end
  end

  // legal start, non-empty mask, last chosen byte seen, CRC equal
  assign hit_o = cfg_i.en && (cfg_i.off >= OFF_W'(OFF_MIN)) && (|cfg_i.mask)
                 && seen_q && (crc_q == cfg_i.crc);

  assert_crc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !sel && !sof_i |=> $stable(crc_q));
  assert_crc_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> crc_q == CRC_INIT && !seen_q);
endmodule

// File: rtl/wkf_wake_ctrl.sv
module wkf_wake_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [3:0] ctl_wdata_i,
  input  logic       pwr_d1_i,
  input  logic       eof_i,
  input  logic       addr_pass_i,
  input  logic       any_hit_i,
  output logic       wake_rcvd_o,
  output logic       irq_o,
  output logic       pme_o,
  output logic       rx_fwd_o
);
  logic en_q, irq_sel_q, pme_sel_q, sts_q;
  logic det_active, set_evt, clr_evt;

  assign det_active = en_q | pwr_d1_i;
  assign set_evt    = det_active & eof_i & addr_pass_i & any_hit_i;
  assign clr_evt    = ctl_wr_i & ctl_wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      irq_sel_q <= 1'b0;
      pme_sel_q <= 1'b0;
      sts_q     <= 1'b0;
    end else begin
      if (ctl_wr_i) {pme_sel_q, irq_sel_q, en_q} <= ctl_wdata_i[2:0];
      sts_q <= set_evt | (sts_q & ~clr_evt);
    end
  end

  assign wake_rcvd_o = sts_q;
  assign irq_o       = sts_q & irq_sel_q;
  assign pme_o       = sts_q & pme_sel_q;
  assign rx_fwd_o    = ~det_active;

  assert_sts_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q && !(ctl_wr_i && ctl_wdata_i[3]) |=> sts_q);
  assert_sts_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_wdata_i[3] && !eof_i |=> !wake_rcvd_o);
  assert_idle_no_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !pwr_d1_i && !sts_q |=> !sts_q);
  assert_addr_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i && !addr_pass_i && !sts_q |=> !sts_q);
  assert_fwd_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_wdata_i[0] |=> !rx_fwd_o);
endmodule

// File: rtl/wkf_pattern_filter.sv
module wkf_pattern_filter
  import wkf_pkg::*;
#(
  parameter int N_FILT = NUM_FILT,
  parameter int W_POS  = POS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_rst_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          ctl_wr_i,
  input  logic [3:0]    ctl_wdata_i,
  input  logic          pwr_d1_i,
  input  logic          sof_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          eof_i,
  input  logic          addr_pass_i,
  output logic          wake_rcvd_o,
  output logic          irq_o,
  output logic          pme_o,
  output logic          rx_fwd_o
);
  filt_cfg_t        cfg [N_FILT];
  logic [N_FILT-1:0] hit;
  logic [W_POS-1:0]  pos_q;

  // position of the byte presented this cycle; saturates on long frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pos_q <= '0;
    else if (sof_i)                     pos_q <= '0;
    else if (byte_vld_i && pos_q != '1) pos_q <= pos_q + 1'b1;
  end

  wkf_cfg_regs #(.N_FILT(N_FILT), .W_DATA(DW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_rst_i   (cfg_rst_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_o       (cfg)
  );

  for (genvar i = 0; i < N_FILT; i++) begin : g_lane
    wkf_filter_lane #(.W_POS(W_POS), .W_MASK(MASK_W), .OFF_MIN(MIN_OFF)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg[i]),
      .sof_i      (sof_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .pos_i      (pos_q),
      .hit_o      (hit[i])
    );
  end

  wkf_wake_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .pwr_d1_i    (pwr_d1_i),
    .eof_i       (eof_i),
    .addr_pass_i (addr_pass_i),
    .any_hit_i   (|hit),
    .wake_rcvd_o (wake_rcvd_o),
    .irq_o       (irq_o),
    .pme_o       (pme_o),
    .rx_fwd_o    (rx_fwd_o)
  );

  assert_pos_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> pos_q == '0);
endmodule

// File: tb/wkf_pattern_filter_tb_top.sv
module wkf_pattern_filter_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_rst, cfg_wr, ctl_wr, pwr_d1, sof, byte_vld, eof, addr_pass;
  logic [31:0] cfg_wdata;
  logic [3:0]  ctl_wdata;
  logic [7:0]  byte_d;
  logic wake, irq, pme, rx_fwd;

  wkf_pattern_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_rst_i(cfg_rst), .cfg_wr_i(cfg_wr),
    .cfg_wdata_i(cfg_wdata), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .pwr_d1_i(pwr_d1), .sof_i(sof), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .eof_i(eof), .addr_pass_i(addr_pass), .wake_rcvd_o(wake), .irq_o(irq),
    .pme_o(pme), .rx_fwd_o(rx_fwd)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0]  frm [0:127];
  logic [30:0] m_mask [4];
  logic [7:0]  m_off  [4];
  logic        m_en   [4];
  logic [15:0] m_crc  [4];

  function automatic logic [15:0] ref_crc(int off, logic [30:0] mask, int len);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < 31; j++) begin
      if (mask[j] && (off + j) < len) begin
        logic [7:0] d = frm[off + j];
        for (int b = 0; b < 8; b++) begin
          logic fb = c[0] ^ d[b];
          c = c >> 1;
          if (fb) c = c ^ 16'hA001;
        end
      end
    end
    return c;
  endfunction

  function automatic bit ref_hit(int i, int len);
    int hi = 0;
    if (!m_en[i] || m_off[i] < 8'd13 || m_mask[i] == '0) return 0;
    for (int j = 0; j < 31; j++) if (m_mask[i][j]) hi = j;
    if (len <= int'(m_off[i]) + hi) return 0;
    return ref_crc(int'(m_off[i]), m_mask[i], len) == m_crc[i];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic load_cfg();
    logic [31:0] cmd = '0;
    for (int i = 0; i < 4; i++) cfg_write({1'b0, m_mask[i]});
    for (int i = 0; i < 4; i++) cmd[8*i] = m_en[i];
    cfg_write(cmd);
    cfg_write({m_off[3], m_off[2], m_off[1], m_off[0]});
    cfg_write({m_crc[1], m_crc[0]});
    cfg_write({m_crc[3], m_crc[2]});
  endtask

  task automatic ctl(logic [3:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic send(int len, bit ap);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    for (int k = 0; k < len; k++) begin
      byte_vld = 1'b1; byte_d = frm[k];
      @(negedge clk);
    end
    byte_vld = 1'b0; eof = 1'b1; addr_pass = ap;
    @(negedge clk); eof = 1'b0; addr_pass = 1'b0;
  endtask

  task automatic put_check_string(int at);
    string s = "123456789";
    for (int k = 0; k < 9; k++) frm[at + k] = s[k];
  endtask

  task automatic base_cfg(int off);
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 1'b0; m_mask[i] = '0; m_off[i] = 8'd20; m_crc[i] = '0;
    end
    m_en[0] = 1'b1; m_off[0] = 8'(off); m_mask[0] = 31'h1FF; m_crc[0] = 16'h4B37;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cfg_rst = 0; cfg_wr = 0; ctl_wr = 0; pwr_d1 = 0; sof = 0;
    byte_vld = 0; eof = 0; addr_pass = 0; cfg_wdata = '0; ctl_wdata = '0; byte_d = '0;
    for (int k = 0; k < 128; k++) frm[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset status", wake, 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset pme", pme, 0);
    chk("R8 reset fwd", rx_fwd, 1);

    // R1: partial sequence discarded by pointer reset
    cfg_write(32'hDEAD_BEEF); cfg_write(32'h1234_5678); cfg_write(32'h0);
    @(negedge clk); cfg_rst = 1; @(negedge clk); cfg_rst = 0;
    put_check_string(20);
    base_cfg(20);
    load_cfg();
    ctl(4'b1111);
    chk("R8 fwd off when enabled", rx_fwd, 0);
    send(40, 1);
    chk("R3 check value 4B37 / R1 order", wake, 1);
    chk("R10 irq selected", irq, 1);
    chk("R10 pme selected", pme, 1);
    ctl(4'b1001);
    chk("R9 w1c clear", wake, 0);
    chk("R10 irq after clear", irq, 0);

    send(40, 0);
    chk("R5 address fail", wake, 0);

    frm[19] = ~frm[19]; frm[29] = ~frm[29]; frm[5] = ~frm[5];
    send(40, 1);
    chk("R2 unmasked bytes ignored", wake, 1);
    ctl(4'b1001);

    send(28, 1);
    chk("R6 frame ends before last masked byte", wake, 0);
    send(29, 1);
    chk("R6 frame just long enough", wake, 1);
    send(40, 0);
    chk("R9 sticky across later frame", wake, 1);
    ctl(4'b1001);

    ctl(4'b0011);
    send(40, 1);
    chk("R10 irq only: irq", irq, 1);
    chk("R10 irq only: pme", pme, 0);
    ctl(4'b0101);
    chk("R10 pme only: irq", irq, 0);
    chk("R10 pme only: pme", pme, 1);
    chk("R9 status kept over select write", wake, 1);
    ctl(4'b1001);

    ctl(4'b0000);
    chk("R8 fwd on when idle", rx_fwd, 1);
    send(40, 1);
    chk("R7 no detection when idle", wake, 0);
    @(negedge clk); pwr_d1 = 1;
    @(negedge clk);
    chk("R8 fwd off in low power", rx_fwd, 0);
    send(40, 1);
    chk("R7 low power forces detection", wake, 1);
    pwr_d1 = 0;
    ctl(4'b1001);

    put_check_string(12);
    base_cfg(12);
    load_cfg();
    send(40, 1);
    chk("R4 start 12 rejected", wake, 0);
    put_check_string(13);
    base_cfg(13);
    load_cfg();
    send(40, 1);
    chk("R4 start 13 accepted", wake, 1);
    ctl(4'b1001);

    m_crc[0] = 16'h0BAD;
    load_cfg();
    send(40, 1);
    chk("R1 wrap overwrote first sequence", wake, 0);
    m_crc[0] = 16'h4B37;
    load_cfg();
    send(40, 1);
    chk("R1 second wrap restores", wake, 1);
    ctl(4'b1001);

    m_en[0] = 0; m_en[3] = 1; m_off[3] = 8'd13; m_mask[3] = 31'h1FF; m_crc[3] = 16'h4B37;
    load_cfg();
    send(40, 1);
    chk("R5 filter 3 alone", wake, 1);
    ctl(4'b1001);

    m_en[3] = 1; m_mask[3] = '0; m_crc[3] = 16'hFFFF;
    load_cfg();
    send(40, 1);
    chk("R6 empty mask never hits", wake, 0);

    for (int it = 0; it < 150; it++) begin
      int L, len;
      bit ap, exp_hit;
      L = int'($urandom_range(20, 100));
      for (int k = 0; k < 128; k++) frm[k] = 8'($urandom);
      for (int i = 0; i < 4; i++) begin
        m_en[i]   = ($urandom % 3) != 0;
        m_off[i]  = 8'($urandom_range(10, 50));
        m_mask[i] = 31'($urandom);
        if ($urandom % 2) m_mask[i] = m_mask[i] & 31'($urandom);
        m_crc[i]  = ($urandom % 2) ? ref_crc(int'(m_off[i]), m_mask[i], L) : 16'($urandom);
      end
      len = (($urandom % 4) == 0) ? int'($urandom_range(14, L)) : L;
      ap  = ($urandom % 4) != 0;
      exp_hit = 0;
      for (int i = 0; i < 4; i++) exp_hit |= ref_hit(i, len);
      ctl(4'b1001);
      load_cfg();
      send(len, ap);
      chk("R5 R2 R3 random frame", wake, 32'(ap && exp_hit));
    end

    finish_run();
  end
endmodule